// File: doc/BRIEF.md
# Accumulator ALU with Packed Flags

This block is the arithmetic and logic stage of an accumulator-based processor. Each operation takes the accumulator value and a second byte as inputs. The caller may have fetched that second byte from a register, from memory or from the instruction stream; the block treats all three the same way. The block returns an 8-bit result and a strobe that says whether the result should be written back into the accumulator. It also keeps a four-bit flag register holding zero, subtract, half-carry and carry.

The flags are always visible as a packed byte. Zero sits in the top bit, then subtract, then half-carry, then carry, and the lower nibble reads as zero. The surrounding core can push this byte onto a stack as it is. A dedicated operation reloads the flags from a byte, which restores a popped value.

The result is combinational from the inputs and the current carry flag. The flag register updates on the clock edge that ends a valid operation.

Top module: `accAlu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add with carry) drive `result` with the low 8 bits of accIn + operand + cin, where cin is the stored carry flag for opcode 1 and 0 for opcode 0. Both raise `accWrite`. The carry flag becomes the carry out of bit 7.
- R2: After opcode 0 or 1, the half-carry flag is 1 exactly when the low nibbles plus cin carry out of bit 3.
- R3: Opcode 2 (subtract) and opcode 3 (subtract with borrow, cin = stored carry) drive `result` with the low 8 bits of accIn − operand − cin and raise `accWrite`. Carry becomes 1 when operand + cin > accIn. Half-carry becomes 1 when the low nibble of the operand plus cin exceeds the low nibble of accIn.
- R4: After opcodes 0–7, the zero flag is 1 exactly when the 8-bit result is 0. The subtract flag is 1 after opcodes 2, 3 and 7 and 0 after opcodes 0, 1, 4, 5 and 6.
- R5: Opcode 7 (compare) sets the flags as opcode 2 does and drives `result` with the difference, but keeps `accWrite` low.
- R6: Opcode 4 (AND), opcode 5 (XOR) and opcode 6 (OR) write the bitwise result. AND leaves half-carry 1 and carry 0. XOR and OR leave both 0.
- R7: Opcode 8 writes the bitwise complement of accIn, sets subtract and half-carry to 1, and leaves zero and carry unchanged.
- R8: Opcode 9 sets carry to 1. Opcode 10 inverts carry. Both clear subtract and half-carry, leave zero unchanged and keep `accWrite` low.
- R9: `flagByte` carries zero in bit 7, subtract in bit 6, half-carry in bit 5 and carry in bit 4. Bits 3:0 always read 0.
- R10: Opcode 11 loads the flags from operand bits 7:4 in the same layout as `flagByte` and ignores operand bits 3:0. It keeps `accWrite` low.
- R11: Reset clears all flags. With `opValid` low, or for opcodes 12–15, the flags hold and `accWrite` is low. Whenever no value is produced (opcodes 9–15 or `opValid` low), `result` equals accIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation select |
| accIn | input | 8 | Accumulator value |
| operand | input | 8 | Second operand byte |
| result | output | 8 | Combinational result |
| accWrite | output | 1 | Write result back to the accumulator |
| flagByte | output | 8 | Packed flag register |

## Verification
A wrong internal flag shows on `flagByte` one cycle after the operation that produced it. A wrong stored carry also shows earlier, in `result`, on the very next add-with-carry or subtract-with-borrow, because those read the carry combinationally. The bench keeps its own flag model, compares `result` and `accWrite` in the same cycle as each operation, and compares `flagByte` one cycle later. A single corrupted flag bit is therefore reported within one operation of its creation.

// File: rtl/accAluPkg.sv
package accAluPkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = DATA_W / 2;
  localparam int FLAG_N = 4;
  localparam int PAD_W  = DATA_W - FLAG_N;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_XOR  = 4'd5,
    OP_OR   = 4'd6,
    OP_CMP  = 4'd7,
    OP_CPL  = 4'd8,
    OP_SETC = 4'd9,
    OP_FLPC = 4'd10,
    OP_LDF  = 4'd11
  } aluOp_e;

  typedef enum logic [1:0] {
    LOG_AND = 2'd0,
    LOG_XOR = 2'd1,
    LOG_OR  = 2'd2
  } logicOp_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  typedef struct packed {
    logic     selArith;
    logic     subtract;
    logic     useCarry;
    logic     selLogic;
    logicOp_e logicOp;
    logic     selCpl;
    logic     selCarryOp;
    logic     forceCarry;
    logic     loadFlags;
    logic     updFlags;
    logic     writeAcc;
  } aluCtrl_t;
endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.logicOp = LOG_AND;
    if (opValid) begin
      case (opCode)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
          ctrl.selArith = 1'b1;
          ctrl.subtract = (opCode == OP_SUB) || (opCode == OP_SBC) || (opCode == OP_CMP);
          ctrl.useCarry = (opCode == OP_ADC) || (opCode == OP_SBC);
          ctrl.updFlags = 1'b1;
          ctrl.writeAcc = (opCode != OP_CMP);
        end
        OP_AND, OP_XOR, OP_OR: begin
          ctrl.selLogic = 1'b1;
          ctrl.logicOp  = (opCode == OP_AND) ? LOG_AND :
                          (opCode == OP_XOR) ? LOG_XOR : LOG_OR;
          ctrl.updFlags = 1'b1;
          ctrl.writeAcc = 1'b1;
        end
        OP_CPL: begin
          ctrl.selCpl   = 1'b1;
          ctrl.updFlags = 1'b1;
          ctrl.writeAcc = 1'b1;
        end
        OP_SETC, OP_FLPC: begin
          ctrl.selCarryOp = 1'b1;
          ctrl.forceCarry = (opCode == OP_SETC);
          ctrl.updFlags   = 1'b1;
        end
        OP_LDF: begin
          ctrl.loadFlags = 1'b1;
          ctrl.updFlags  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/accAluDatapath.sv
module accAluDatapath
  import accAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctrl,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] flagByte
);
  flags_t flagQ, flagD;
  logic cin;
  logic [DATA_W:0] addFull, subFull;
  logic [HALF_W:0] addHalf, subHalf;
  logic [DATA_W-1:0] logicRes, resD;

  assign cin = ctrl.useCarry & flagQ.c;

  assign addFull = {1'b0, accIn} + {1'b0, operand} + {{DATA_W{1'b0}}, cin};
  assign subFull = {1'b0, accIn} - {1'b0, operand} - {{DATA_W{1'b0}}, cin};
  assign addHalf = {1'b0, accIn[HALF_W-1:0]} + {1'b0, operand[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin};
  assign subHalf = {1'b0, accIn[HALF_W-1:0]} - {1'b0, operand[HALF_W-1:0]}
                 - {{HALF_W{1'b0}}, cin};

  always_comb begin
    case (ctrl.logicOp)
      LOG_AND: logicRes = accIn & operand;
      LOG_XOR: logicRes = accIn ^ operand;
      default: logicRes = accIn | operand;
    endcase
  end

  always_comb begin
    resD  = accIn;
    flagD = flagQ;
    if (ctrl.selArith) begin
      resD    = ctrl.subtract ? subFull[DATA_W-1:0] : addFull[DATA_W-1:0];
      flagD.z = (resD == '0);
      flagD.n = ctrl.subtract;
      flagD.h = ctrl.subtract ? subHalf[HALF_W] : addHalf[HALF_W];
      flagD.c = ctrl.subtract ? subFull[DATA_W] : addFull[DATA_W];
    end else if (ctrl.selLogic) begin
      resD    = logicRes;
      flagD.z = (resD == '0);
      flagD.n = 1'b0;
      flagD.h = (ctrl.logicOp == LOG_AND);
      flagD.c = 1'b0;
    end else if (ctrl.selCpl) begin
      resD    = ~accIn;
      flagD.n = 1'b1;
      flagD.h = 1'b1;
    end else if (ctrl.selCarryOp) begin
      flagD.n = 1'b0;
      flagD.h = 1'b0;
      flagD.c = ctrl.forceCarry | ~flagQ.c;
    end else if (ctrl.loadFlags) begin
      flagD = flags_t'(operand[DATA_W-1 -: FLAG_N]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              flagQ <= '0;
    else if (ctrl.updFlags) flagQ <= flagD;
  end

  assign result   = resD;
  assign flagByte = {flagQ, {PAD_W{1'b0}}};
endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [3:0] opCode,
  input  logic [7:0] accIn,
  input  logic [7:0] operand,
  output logic [7:0] result,
  output logic       accWrite,
  output logic [7:0] flagByte
);
  aluCtrl_t ctrl;

  accAluCtrl uCtrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctrl    (ctrl)
  );

  accAluDatapath uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .accIn    (accIn),
    .operand  (operand),
    .result   (result),
    .flagByte (flagByte)
  );

  assign accWrite = ctrl.writeAcc;
endmodule

// File: rtl/accAluChk.sv
module accAluChk (
  input logic       clk,
  input logic       rstN,
  input logic       opValid,
  input logic [3:0] opCode,
  input logic [7:0] accIn,
  input logic [7:0] result,
  input logic       accWrite,
  input logic [7:0] flagByte
);
  // R9
  low_nibble_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagByte[3:0] == 4'b0000);

  // R11
  idle_flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(flagByte));

  // R11
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !accWrite);

  // R5
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd7) |-> !accWrite);

  // R8
  set_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd9) |=> (flagByte[6:4] == 3'b001));

  // R8
  flip_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd10) |=> (flagByte[4] != $past(flagByte[4])));

  // R7
  complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd8) |-> (result == ~accIn && accWrite));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode < 4'd8) |=> (flagByte[7] == ($past(result) == 8'h00)));
endmodule

bind accAlu accAluChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .accIn    (accIn),
  .result   (result),
  .accWrite (accWrite),
  .flagByte (flagByte)
);

// File: tb/sim_accAlu.sv
module sim_accAlu;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] accIn = 8'd0;
  logic [7:0] operand = 8'd0;
  logic [7:0] result;
  logic accWrite;
  logic [7:0] flagByte;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [3:0] mFlags;  // {z,n,h,c}

  always #(CLK_PERIOD/2) clk = ~clk;

  accAlu u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .accIn(accIn), .operand(operand), .result(result),
    .accWrite(accWrite), .flagByte(flagByte)
  );

  // returns {write, result[7:0], flags[3:0]}
  function automatic logic [12:0] model(input logic v, input logic [3:0] op,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic [3:0] f);
    logic z = f[3], n = f[2], h = f[1], c = f[0];
    logic [7:0] r = a;
    logic w = 1'b0;
    int cin, s;
    if (!v) return {1'b0, a, f};
    cin = ((op == 4'd1 || op == 4'd3) && c) ? 1 : 0;
    case (op)
      4'd0, 4'd1: begin
        s = int'(a) + int'(b) + cin; r = s[7:0]; w = 1;
        z = (r == 0); n = 0;
        h = (int'(a[3:0]) + int'(b[3:0]) + cin) > 15; c = s > 255;
      end
      4'd2, 4'd3, 4'd7: begin
        s = int'(a) - int'(b) - cin; r = s[7:0]; w = (op != 4'd7);
        z = (r == 0); n = 1;
        h = (int'(b[3:0]) + cin) > int'(a[3:0]); c = (int'(b) + cin) > int'(a);
      end
      4'd4: begin r = a & b; w = 1; z = (r == 0); n = 0; h = 1; c = 0; end
      4'd5: begin r = a ^ b; w = 1; z = (r == 0); n = 0; h = 0; c = 0; end
      4'd6: begin r = a | b; w = 1; z = (r == 0); n = 0; h = 0; c = 0; end
      4'd8: begin r = ~a; w = 1; n = 1; h = 1; end
      4'd9: begin n = 0; h = 0; c = 1; end
      4'd10: begin n = 0; h = 0; c = ~c; end
      4'd11: begin z = b[7]; n = b[6]; h = b[5]; c = b[4]; end
      default: ;
    endcase
    return {w, r, z, n, h, c};
  endfunction

  function automatic string tagOf(input logic v, input logic [3:0] op);
    if (!v) return "R11";
    case (op)
      4'd0, 4'd1: return "R1/R2/R4";
      4'd2, 4'd3: return "R3/R4";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd7: return "R5";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11: return "R10/R9";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic doOp(input logic v, input logic [3:0] op,
                      input logic [7:0] a, input logic [7:0] b);
    logic [12:0] e;
    opValid = v; opCode = op; accIn = a; operand = b;
    #1;
    e = model(v, op, a, b, mFlags);
    check(tagOf(v, op), "result", result, e[11:4]);
    check(tagOf(v, op), "accWrite", accWrite, e[12]);
    @(negedge clk);
    mFlags = e[3:0];
    check(tagOf(v, op), "flagByte", flagByte, {mFlags, 4'b0000});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    mFlags = 4'b0000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "reset flagByte", flagByte, 8'h00);
    check("R11", "reset accWrite", accWrite, 0);

    doOp(1, 4'd0, 8'h0F, 8'h01);  // R2 half carry
    doOp(1, 4'd0, 8'hFF, 8'h01);  // R1 carry + zero
    doOp(1, 4'd1, 8'h10, 8'h0F);  // R1 carry in used, R2 half carry
    doOp(1, 4'd2, 8'h10, 8'h01);  // R3 half borrow
    doOp(1, 4'd9, 8'h00, 8'h00);  // R8 set carry
    doOp(1, 4'd3, 8'h05, 8'h05);  // R3 borrow from carry in
    doOp(1, 4'd7, 8'h42, 8'h42);  // R5 compare equal
    doOp(1, 4'd4, 8'hF0, 8'h0F);  // R6 AND zero
    doOp(1, 4'd10, 8'h00, 8'h00); // R8 flip carry
    doOp(1, 4'd8, 8'h5A, 8'h00);  // R7 complement
    doOp(1, 4'd11, 8'h33, 8'hFF); // R10 low nibble ignored, R9 layout
    doOp(1, 4'd11, 8'h33, 8'h5A); // R10
    doOp(0, 4'd0, 8'h01, 8'h01);  // R11 idle
    doOp(1, 4'd14, 8'h77, 8'h88); // R11 unused opcode

    for (int i = 0; i < 6000; i++) begin
      logic v = ($urandom_range(0, 9) != 0);
      doOp(v, 4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule